// File: doc/BRIEF.md
# Paired-Direction Parallel I/O Bank

A bank of 32 general-purpose pins behind a plain 32-bit register bus. Each pin carries a two-bit direction code that says whether it is unused, drives out, listens, or does both; the codes for the upper-numbered and lower-numbered halves of the bank live in two separate direction words. A single data word holds the values driven onto output pins. Reads of that word return what the pins actually show: the latched value for pins that only drive, and the synchronised pad level for all others.

Pins are numbered from the most significant end: pin 0 is data bit 31 and pin 31 is data bit 0. Besides whole-word writes, software may issue single-pin commands that turn one pin into an input, or drive it high or low, without a read-modify-write. It may also query one pin as a single boolean. Pad inputs pass through two flops before any read can see them.

Top module: `pio_bank32`

## Requirements
- R1: After reset both direction words, the data word, `pad_out` and `pad_oe` are all zero.
- R2: Offset 0x00 holds the codes for pins 0-15 and offset 0x04 those for pins 16-31. Pin n uses bits (31-2m) and (30-2m) of its word, m = n mod 16, with the lower of the two bits as the code's bit 0. Both words read back as written.
- R3: Codes are 00 unused, 01 output, 10 input and 11 input/output. `pad_oe` bit (31-n) is high exactly when pin n has code 01 or 11.
- R4: The data word at offset 0x08 is written whole, and `pad_out` always equals it, so pin n drives data bit (31-n).
- R5: Reading offset 0x08 gives, for each pin, the stored data bit if its code is 01, and the synchronised pad level otherwise.
- R6: A change on `pad_in` first shows in a read after the second rising clock edge that follows it.
- R7: A write to offset 0x0C with bits [31:30] = 01 sets the code of pin bits [4:0] to 10. All other codes and all data bits stay unchanged.
- R8: A write to offset 0x0C with bits [31:30] = 1x sets that pin's code to 01 and its data bit to bit 30. All other codes and data bits stay unchanged.
- R9: A read at offset 0x80 + 4n returns, in bit 0, the value an offset-0x08 read would show for pin n. All other bits read as zero.
- R10: A pin command with bits [31:30] = 00 changes nothing. Offset 0x0C reads as zero. Writes to unmapped offsets change no state, and reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Pad levels, bit 31 is pin 0 |
| pad_out | output | 32 | Values driven to pads |
| pad_oe | output | 32 | Output enables, high drives |

## Verification
The bench sets every pin to every one of the four codes in turn. After each change it compares the full enable vector and the read-back direction word. This catches a field landing at the wrong position, in the wrong half, or with its bit order reversed. Data reads are tried with all pins output-only, all input, all bidirectional and with interleaved codes. The pads always hold the complement of the latched data, so the bench can tell which source feeds each bit. Single-pin commands are walked across every pin, each followed by a check of both direction words and the data word, so a stray change to a neighbouring pin shows up. A step on the pads is read at zero, one and two edges to pin down the synchroniser's latency.

// File: rtl/pio_bank32.sv
module pio_bank32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] pad_in,
  output logic [31:0] pad_out,
  output logic [31:0] pad_oe
);
  localparam logic [7:0] OFS_DIR_A = 8'h00;
  localparam logic [7:0] OFS_DIR_B = 8'h04;
  localparam logic [7:0] OFS_DATA  = 8'h08;
  localparam logic [7:0] OFS_CMD   = 8'h0C;

  logic [31:0] dir_a, dir_b, dat, sync1, sync2, view;
  logic [1:0]  cmd_op;
  logic [4:0]  cmd_pin, fld_sh;
  logic [31:0] fld_mask, fld_val;
  logic        cmd_go;

  assign cmd_op   = bus_wdata[31:30];
  assign cmd_pin  = bus_wdata[4:0];
  assign fld_sh   = {~cmd_pin[3:0], 1'b0};
  assign fld_mask = 32'h3 << fld_sh;
  assign fld_val  = (cmd_op[1] ? 32'h1 : 32'h2) << fld_sh;
  assign cmd_go   = bus_wr && bus_addr == OFS_CMD && cmd_op != 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_a <= '0;
      dir_b <= '0;
      dat   <= '0;
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
      if (bus_wr) begin
        case (bus_addr)
          OFS_DIR_A: dir_a <= bus_wdata;
          OFS_DIR_B: dir_b <= bus_wdata;
          OFS_DATA:  dat   <= bus_wdata;
          default: ;
        endcase
      end
      if (cmd_go) begin
        if (!cmd_pin[4]) dir_a <= (dir_a & ~fld_mask) | fld_val;
        else             dir_b <= (dir_b & ~fld_mask) | fld_val;
        if (cmd_op[1]) dat[~cmd_pin] <= cmd_op[0];
      end
    end
  end

  for (genvar b = 0; b < 32; b++) begin : g_pin
    logic [1:0] code;
    if (b >= 16) begin : g_a
      assign code = dir_a[2*(b-16) +: 2];
    end else begin : g_b
      assign code = dir_b[2*b +: 2];
    end
    assign pad_oe[b] = code[0];
    assign view[b]   = (code == 2'b01) ? dat[b] : sync2[b];
  end

  assign pad_out = dat;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[7]) begin
      if (bus_addr[1:0] == 2'b00) bus_rdata[0] = view[~bus_addr[6:2]];
    end else begin
      case (bus_addr)
        OFS_DIR_A: bus_rdata = dir_a;
        OFS_DIR_B: bus_rdata = dir_b;
        OFS_DATA:  bus_rdata = view;
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pio_bank32_chk.sv
module pio_bank32_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [31:0] pad_in,
  input logic [31:0] pad_out,
  input logic [31:0] pad_oe
);
  function automatic logic [15:0] low_of_pairs(input logic [31:0] x);
    for (int k = 0; k < 16; k++) low_of_pairs[k] = x[2*k];
  endfunction

  p_oe_from_dir_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h00) |=> pad_oe[31:16] == low_of_pairs($past(bus_wdata)));

  p_oe_from_dir_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h04) |=> pad_oe[15:0] == low_of_pairs($past(bus_wdata)));

  p_data_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h08) |=> pad_out == $past(bus_wdata));

  p_cmd_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h0C && bus_wdata[31]) |=>
      (pad_oe[~$past(bus_wdata[4:0])] && pad_out[~$past(bus_wdata[4:0])] == $past(bus_wdata[30])));

  p_cmd_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h0C && bus_wdata[31:30] == 2'b01) |=> !pad_oe[~$past(bus_wdata[4:0])]);

  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr || (bus_addr != 8'h08 && bus_addr != 8'h0C)) |=> $stable(pad_out));
endmodule

bind pio_bank32 pio_bank32_chk chk_i (.*);

// File: tb/pio_bank32_tb_top.sv
module pio_bank32_tb_top;
  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, pad_in = 0;
  logic [31:0] bus_rdata, pad_out, pad_oe;
  int errors = 0, checks = 0;
  logic [31:0] m_a = 0, m_b = 0, m_d = 0;

  always #2.5 clk = ~clk;

  pio_bank32 dut_i (.*);

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  function automatic logic [1:0] code_of(input int n);
    logic [31:0] w;
    int lo;
    w  = (n < 16) ? m_a : m_b;
    lo = 30 - 2 * (n % 16);
    return {w[lo+1], w[lo]};
  endfunction

  function automatic logic [31:0] exp_oe();
    for (int n = 0; n < 32; n++) exp_oe[31-n] = code_of(n)[0];
  endfunction

  function automatic logic [31:0] exp_view();
    for (int n = 0; n < 32; n++)
      exp_view[31-n] = (code_of(n) == 2'b01) ? m_d[31-n] : pad_in[31-n];
  endfunction

  task automatic set_code(input int n, input logic [1:0] c);
    int lo;
    lo = 30 - 2 * (n % 16);
    if (n < 16) begin m_a[lo] = c[0]; m_a[lo+1] = c[1]; end
    else        begin m_b[lo] = c[0]; m_b[lo+1] = c[1]; end
  endtask

  task automatic check_all(input string req);
    logic [31:0] v;
    rd(8'h00, v); chk({req, " dirA"}, v, m_a);
    rd(8'h04, v); chk({req, " dirB"}, v, m_b);
    chk({req, " pad_out"}, pad_out, m_d);
    chk({req, " pad_oe"}, pad_oe, exp_oe());
    rd(8'h08, v); chk({req, " view"}, v, exp_view());
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] pats [4];
    logic [31:0] dirs [4];
    pats = '{32'hA5A5_0F0F, 32'hFFFF_0000, 32'h0000_0001, 32'h8000_0000};
    dirs = '{32'h5555_5555, 32'hAAAA_AAAA, 32'hFFFF_FFFF, 32'h1B1B_E4E4};
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(8'h00, v); chk("R1 dirA", v, 0);
    rd(8'h04, v); chk("R1 dirB", v, 0);
    rd(8'h08, v); chk("R1 data", v, 0);
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 pad_out", pad_out, 0);

    // R2 R3 every pin through every code
    for (int n = 0; n < 32; n++)
      for (int c = 0; c < 4; c++) begin
        set_code(n, 2'(c));
        if (n < 16) wr(8'h00, m_a); else wr(8'h04, m_b);
        rd((n < 16) ? 8'h00 : 8'h04, v);
        chk("R2 dir readback", v, (n < 16) ? m_a : m_b);
        chk("R3 oe per code", pad_oe, exp_oe());
      end

    // R4 R5 data path under four direction patterns
    for (int d = 0; d < 4; d++) begin
      m_a = dirs[d]; m_b = {dirs[d][15:0], dirs[d][31:16]};
      wr(8'h00, m_a); wr(8'h04, m_b);
      for (int p = 0; p < 4; p++) begin
        m_d = pats[p];
        wr(8'h08, m_d);
        pad_in = ~pats[p];
        repeat (2) @(negedge clk);
        chk("R4 pad_out", pad_out, m_d);
        chk("R3 pad_oe", pad_oe, exp_oe());
        rd(8'h08, v); chk("R5 data view", v, exp_view());
      end
    end

    // R6 synchroniser latency, all pins input
    m_a = 32'hAAAA_AAAA; m_b = m_a;
    wr(8'h00, m_a); wr(8'h04, m_b);
    pad_in = 32'h0; repeat (3) @(negedge clk);
    pad_in = 32'h3C3C_F00F;
    rd(8'h08, v); chk("R6 zero edges", v, 32'h0);
    @(negedge clk); rd(8'h08, v); chk("R6 one edge", v, 32'h0);
    @(negedge clk); rd(8'h08, v); chk("R6 two edges", v, 32'h3C3C_F00F);

    // R7 R8 single-pin commands across the bank
    m_a = 32'h1B1B_1B1B; m_b = 32'hE4E4_E4E4; m_d = 32'h0F0F_3355;
    wr(8'h00, m_a); wr(8'h04, m_b); wr(8'h08, m_d);
    pad_in = ~m_d; repeat (2) @(negedge clk);
    for (int n = 0; n < 32; n++) begin
      wr(8'h0C, {2'b11, 25'h0, 5'(n)});
      set_code(n, 2'b01); m_d[31-n] = 1'b1;
      check_all("R8 drive high");
      wr(8'h0C, {2'b10, 25'h0, 5'(n)});
      set_code(n, 2'b01); m_d[31-n] = 1'b0;
      check_all("R8 drive low");
      if (n % 3 != 0) begin
        wr(8'h0C, {2'b01, 25'h0, 5'(n)});
        set_code(n, 2'b10);
        check_all("R7 make input");
      end
    end
    wr(8'h0C, {2'b00, 25'h0, 5'd7});
    check_all("R10 nop command");

    // R9 single-pin query
    pad_in = 32'h6996_A55A; repeat (2) @(negedge clk);
    for (int n = 0; n < 32; n++) begin
      rd(8'h80 + 8'(4 * n), v);
      chk("R9 pin query", v, {31'h0, exp_view()[31-n]});
    end

    // R10 unmapped offsets and command read
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h7C, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R10 unmapped read", v, 0);
    rd(8'h0C, v); chk("R10 cmd read", v, 0);
    rd(8'h81, v); chk("R10 misaligned query", v, 0);
    check_all("R10 state kept");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule